// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every bus cycle the processor issues and compares it against two independently programmed break conditions, channel A and channel B. A condition covers a masked address, an 8-bit address-space identifier, and three cycle-type selectors: bus domain, access kind and direction. Channel B also compares masked data. When a sampled bus cycle satisfies a channel's condition, the block raises a one-clock break request toward the CPU. It also sets a sticky match flag for that channel in the domain the cycle came from.

Software programs the conditions through a small word-wide register port and polls or clears the flags through the same port. The monitor input carries the cycle's address, data, identifier, domain code, fetch/data kind, direction and a valid strobe. When both channels hit on the same cycle, the CPU sees one request, and both channels record their flags.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset, `brk_req` is 0 and every register reads 0, so both channels start disabled.
- R2: An address bit is compared only where the channel's address mask bit is 0. A mask bit of 1 makes that bit don't-care.
- R3: A channel matches only when `mon_asid` equals its 8-bit identifier register exactly.
- R4: Each selector field uses 01 for the first option, 10 for the second option and 11 for either option. The condition register holds the domain selector in bits [1:0] (01 = L bus, 10 = I bus), the kind selector in bits [3:2] (01 = instruction fetch, 10 = data access) and the direction selector in bits [5:4] (01 = read, 10 = write). A cycle matches only when all three selectors accept it.
- R5: If any one of the three selector fields of a channel holds 00, that channel never matches.
- R6: Channel B also requires `mon_data` to equal its data register on every bit where its data mask is 0. Channel A ignores `mon_data`.
- R7: `brk_req` is high for exactly the one clock after each cycle in which `mon_valid` was high and some channel matched. It stays low otherwise.
- R8: A match on a cycle with `mon_dom` = 00 (L bus) sets the channel's L flag. A match with `mon_dom` = 01 (I bus) sets its I flag. The flag register bits are: [0] A-L, [1] A-I, [2] B-L, [3] B-I.
- R9: When channel B's condition bit 6 is 1, a cycle with `mon_dom` = 10 (X/Y memory bus) passes channel B's domain test, and a match there sets B-L. Channel A never matches `mon_dom` = 10, and `mon_dom` = 11 matches no channel.
- R10: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A clear in the same cycle as a hardware set leaves the flag set.
- R11: A simultaneous match on both channels gives a single one-clock `brk_req` and sets both channels' flags.
- R12: The register map is: 0 A address, 1 A mask, 2 A identifier, 3 A condition, 4 B address, 5 B mask, 6 B identifier, 7 B condition, 8 B data, 9 B data mask, 10 flags. Each register reads back what was written, zero-extended to its width. Writes take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mon_valid | input | 1 | Monitored bus cycle is valid this clock |
| mon_addr | input | 32 | Cycle address |
| mon_data | input | 32 | Cycle data |
| mon_asid | input | 8 | Cycle address-space identifier |
| mon_dom | input | 2 | Bus domain: 00 L, 01 I, 10 X/Y, 11 reserved |
| mon_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| mon_write | input | 1 | 1 = write, 0 = read |
| brk_req | output | 1 | Break request pulse to the CPU |

## Verification
The assertions assume that every monitor input is stable and defined around the rising edge whenever `mon_valid` is high. They also assume that `reg_addr` never selects an index above 10, and that the only events that can lower a flag are writes to index 10. The stimulus respects this by changing all inputs only at the falling edge, by using only the eleven defined indices, and by mixing flag-clear writes with matching bus cycles in the same clock, so the set-over-clear rule is actually exercised.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NCH      = 2;
  localparam int REG_AW   = 4;
  localparam int CH_SPAN  = 4;
  localparam int NFLAG    = 2 * NCH;
  localparam int COND_W   = 7;
  localparam logic [REG_AW-1:0] IDX_DAT   = 4'd8;
  localparam logic [REG_AW-1:0] IDX_DMSK  = 4'd9;
  localparam logic [REG_AW-1:0] IDX_FLAGS = 4'd10;

  localparam logic [1:0] DOM_L  = 2'b00;
  localparam logic [1:0] DOM_I  = 2'b01;
  localparam logic [1:0] DOM_XY = 2'b10;

  typedef struct packed {
    logic       xy_en;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] dom;
  } cond_t;

  function automatic logic sel_ok(input logic [1:0] sel, input logic first, input logic second);
    return (sel[0] & first) | (sel[1] & second);
  endfunction

  function automatic logic cond_armed(input cond_t c);
    return (c.dom != 2'b00) && (c.kind != 2'b00) && (c.dir != 2'b00);
  endfunction
endpackage

// File: rtl/brk_chan.sv
module brk_chan import brk_pkg::*; #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int IW       = 8,
  parameter bit HAS_DATA = 1'b0,
  parameter bit XY_CAP   = 1'b0
) (
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_amask,
  input  logic [IW-1:0] cfg_asid,
  input  cond_t         cfg_cond,
  input  logic [DW-1:0] cfg_dat,
  input  logic [DW-1:0] cfg_dmask,
  input  logic          mon_valid,
  input  logic [AW-1:0] mon_addr,
  input  logic [DW-1:0] mon_data,
  input  logic [IW-1:0] mon_asid,
  input  logic [1:0]    mon_dom,
  input  logic          mon_fetch,
  input  logic          mon_write,
  output logic          armed,
  output logic          hit,
  output logic          hit_l,
  output logic          hit_i
);
  function automatic logic addr_eq(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                   input logic [AW-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  logic in_l, in_i, in_xy;
  logic dom_ok, kind_ok, dir_ok, addr_ok, asid_ok, data_ok;

  assign in_l  = (mon_dom == DOM_L);
  assign in_i  = (mon_dom == DOM_I);
  assign in_xy = (mon_dom == DOM_XY);

  assign armed   = cond_armed(cfg_cond);
  assign dom_ok  = sel_ok(cfg_cond.dom, in_l, in_i) | (XY_CAP & cfg_cond.xy_en & in_xy);
  assign kind_ok = sel_ok(cfg_cond.kind, mon_fetch, ~mon_fetch);
  assign dir_ok  = sel_ok(cfg_cond.dir, ~mon_write, mon_write);
  assign addr_ok = addr_eq(mon_addr, cfg_addr, cfg_amask);
  assign asid_ok = (mon_asid == cfg_asid);

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ((mon_data ^ cfg_dat) & ~cfg_dmask) == '0;
    end else begin : g_nodata
      logic unused_dat;
      assign unused_dat = ^{mon_data, cfg_dat, cfg_dmask};
      assign data_ok    = 1'b1;
    end
  endgenerate

  assign hit   = mon_valid & armed & dom_ok & kind_ok & dir_ok & addr_ok & asid_ok & data_ok;
  assign hit_i = hit & in_i;
  assign hit_l = hit & ~in_i;
endmodule

// File: rtl/brk_flags.sv
module brk_flags import brk_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_v,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_val,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] keep;
  assign keep = clr_we ? clr_val : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & keep) | set_v;
  end
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit import brk_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int RW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              mon_valid,
  input  logic [AW-1:0]     mon_addr,
  input  logic [DW-1:0]     mon_data,
  input  logic [IW-1:0]     mon_asid,
  input  logic [1:0]        mon_dom,
  input  logic              mon_fetch,
  input  logic              mon_write,
  output logic              brk_req
);
  logic [AW-1:0] addr_q  [NCH];
  logic [AW-1:0] amask_q [NCH];
  logic [IW-1:0] asid_q  [NCH];
  cond_t         cond_q  [NCH];
  logic [DW-1:0] dat_q, dmask_q;

  logic [NCH-1:0]   hit_v, hit_l_v, hit_i_v, armed_v;
  logic             hit_a, hit_b, armed_a, armed_b;
  logic [NFLAG-1:0] flag_set, flags;
  logic             clr_we;

  function automatic logic [REG_AW-1:0] idx(input int ch, input int off);
    return REG_AW'(ch * CH_SPAN + off);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        addr_q[c]  <= '0;
        amask_q[c] <= '0;
        asid_q[c]  <= '0;
        cond_q[c]  <= '0;
      end
      dat_q   <= '0;
      dmask_q <= '0;
    end else if (reg_wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == idx(c, 0)) addr_q[c]  <= reg_wdata[AW-1:0];
        if (reg_addr == idx(c, 1)) amask_q[c] <= reg_wdata[AW-1:0];
        if (reg_addr == idx(c, 2)) asid_q[c]  <= reg_wdata[IW-1:0];
        if (reg_addr == idx(c, 3)) cond_q[c]  <= cond_t'(reg_wdata[COND_W-1:0]);
      end
      if (reg_addr == IDX_DAT)  dat_q   <= reg_wdata[DW-1:0];
      if (reg_addr == IDX_DMSK) dmask_q <= reg_wdata[DW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == idx(c, 0)) reg_rdata[AW-1:0]     = addr_q[c];
      if (reg_addr == idx(c, 1)) reg_rdata[AW-1:0]     = amask_q[c];
      if (reg_addr == idx(c, 2)) reg_rdata[IW-1:0]     = asid_q[c];
      if (reg_addr == idx(c, 3)) reg_rdata[COND_W-1:0] = cond_q[c];
    end
    if (reg_addr == IDX_DAT)   reg_rdata[DW-1:0]    = dat_q;
    if (reg_addr == IDX_DMSK)  reg_rdata[DW-1:0]    = dmask_q;
    if (reg_addr == IDX_FLAGS) reg_rdata[NFLAG-1:0] = flags;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      brk_chan #(
        .AW(AW), .DW(DW), .IW(IW),
        .HAS_DATA(c == NCH - 1), .XY_CAP(c == NCH - 1)
      ) u_chan (
        .cfg_addr(addr_q[c]), .cfg_amask(amask_q[c]), .cfg_asid(asid_q[c]),
        .cfg_cond(cond_q[c]), .cfg_dat(dat_q), .cfg_dmask(dmask_q),
        .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_data(mon_data),
        .mon_asid(mon_asid), .mon_dom(mon_dom), .mon_fetch(mon_fetch),
        .mon_write(mon_write),
        .armed(armed_v[c]), .hit(hit_v[c]), .hit_l(hit_l_v[c]), .hit_i(hit_i_v[c])
      );
      assign flag_set[2*c]   = hit_l_v[c];
      assign flag_set[2*c+1] = hit_i_v[c];
    end
  endgenerate

  assign hit_a   = hit_v[0];
  assign hit_b   = hit_v[1];
  assign armed_a = armed_v[0];
  assign armed_b = armed_v[1];
  assign clr_we  = reg_wr_en && (reg_addr == IDX_FLAGS);

  brk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(flag_set), .clr_we(clr_we),
    .clr_val(reg_wdata[NFLAG-1:0]), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= |hit_v;
  end
endmodule

// File: rtl/brk_checker.sv
module brk_checker import brk_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_valid,
  input logic             hit_a,
  input logic             hit_b,
  input logic             armed_a,
  input logic             armed_b,
  input logic [NFLAG-1:0] flag_set,
  input logic [NFLAG-1:0] flags,
  input logic             clr_we,
  input logic             brk_req
);
  p_req_follows_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a || hit_b) |=> brk_req);

  p_req_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a || hit_b) |=> !brk_req);

  p_idle_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_valid |-> !(hit_a || hit_b));

  p_disarmed_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_a |-> !hit_a);

  p_disarmed_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_b |-> !hit_b);

  p_set_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags)) != '0) |-> $past(clr_we));

  p_both_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && hit_b) |=> ((flags[0] || flags[1]) && (flags[2] || flags[3])));
endmodule

bind dbg_break_unit brk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid),
  .hit_a(hit_a), .hit_b(hit_b), .armed_a(armed_a), .armed_b(armed_b),
  .flag_set(flag_set), .flags(flags), .clr_we(clr_we), .brk_req(brk_req)
);

// File: tb/tb_dbg_break_unit.sv
`timescale 1ns/1ps
module tb_dbg_break_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mon_valid;
  logic [31:0] mon_addr, mon_data;
  logic [7:0]  mon_asid;
  logic [1:0]  mon_dom;
  logic        mon_fetch, mon_write;
  logic        brk_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbg_break_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_data(mon_data), .mon_asid(mon_asid),
    .mon_dom(mon_dom), .mon_fetch(mon_fetch), .mon_write(mon_write),
    .brk_req(brk_req)
  );

  // bench-side model state
  logic [31:0] m_addr [2];
  logic [31:0] m_mask [2];
  logic [7:0]  m_asid [2];
  logic [6:0]  m_cond [2];
  logic [31:0] m_dat, m_dmask;
  logic [3:0]  m_flags;

  bit    exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_bits_eq(input logic [31:0] a, input logic [31:0] b, input logic [31:0] m);
    for (int i = 0; i < 32; i++)
      if (!m[i] && (a[i] != b[i])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_hit(input int c, input logic [31:0] a, input logic [31:0] d,
                               input logic [7:0] id, input logic [1:0] dm, input bit f, input bit w);
    logic [6:0] k;
    bit dok;
    k = m_cond[c];
    if (k[1:0] == 2'b00 || k[3:2] == 2'b00 || k[5:4] == 2'b00) return 1'b0;
    case (dm)
      2'b00:   dok = k[0];
      2'b01:   dok = k[1];
      2'b10:   dok = (c == 1) && k[6];
      default: dok = 1'b0;
    endcase
    if (!dok) return 1'b0;
    if (!(f ? k[2] : k[3])) return 1'b0;
    if (!(w ? k[5] : k[4])) return 1'b0;
    if (!m_bits_eq(a, m_addr[c], m_mask[c])) return 1'b0;
    if (id != m_asid[c]) return 1'b0;
    if (c == 1 && !m_bits_eq(d, m_dat, m_dmask)) return 1'b0;
    return 1'b1;
  endfunction

  // driver: one clock of stimulus, expected request pushed to the scoreboard
  task automatic cyc(input bit v, input logic [31:0] a, input logic [31:0] d, input logic [7:0] id,
                     input logic [1:0] dm, input bit f, input bit w,
                     input bit we, input logic [3:0] ra, input logic [31:0] wd, input string tag);
    bit ha, hb;
    logic [3:0] setv;
    @(negedge clk);
    mon_valid = v; mon_addr = a; mon_data = d; mon_asid = id;
    mon_dom = dm; mon_fetch = f; mon_write = w;
    reg_wr_en = we; reg_addr = ra; reg_wdata = wd;
    ha = v && m_hit(0, a, d, id, dm, f, w);
    hb = v && m_hit(1, a, d, id, dm, f, w);
    exp_q.push_back(ha | hb);
    tag_q.push_back(tag);
    setv = {hb && dm == 2'b01, hb && dm != 2'b01, ha && dm == 2'b01, ha && dm != 2'b01};
    if (we && ra == 4'd10) m_flags = m_flags & wd[3:0];
    m_flags = m_flags | setv;
    if (we) begin
      case (ra)
        4'd0: m_addr[0] = wd;       4'd1: m_mask[0] = wd;
        4'd2: m_asid[0] = wd[7:0];  4'd3: m_cond[0] = wd[6:0];
        4'd4: m_addr[1] = wd;       4'd5: m_mask[1] = wd;
        4'd6: m_asid[1] = wd[7:0];  4'd7: m_cond[1] = wd[6:0];
        4'd8: m_dat = wd;           4'd9: m_dmask = wd;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] ra, input logic [31:0] wd);
    cyc(1'b0, '0, '0, '0, 2'b00, 1'b0, 1'b0, 1'b1, ra, wd, "R12 write");
  endtask

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic [7:0] id,
                     input logic [1:0] dm, input bit f, input bit w, input string tag);
    cyc(1'b1, a, d, id, dm, f, w, 1'b0, 4'd0, '0, tag);
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] ra);
    case (ra)
      4'd0: return m_addr[0];             4'd1: return m_mask[0];
      4'd2: return {24'b0, m_asid[0]};    4'd3: return {25'b0, m_cond[0]};
      4'd4: return m_addr[1];             4'd5: return m_mask[1];
      4'd6: return {24'b0, m_asid[1]};    4'd7: return {25'b0, m_cond[1]};
      4'd8: return m_dat;                 4'd9: return m_dmask;
      4'd10: return {28'b0, m_flags};
      default: return '0;
    endcase
  endfunction

  task automatic rd(input logic [3:0] ra, input string req);
    logic [31:0] e;
    cyc(1'b0, '0, '0, '0, 2'b00, 1'b0, 1'b0, 1'b0, ra, '0, "R7 idle read");
    #1;
    e = m_read(ra);
    chk(reg_rdata === e, req, reg_rdata, e);
  endtask

  // monitor: pops one expectation per clock, after the registered output settles
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(brk_req === e, t, {31'b0, brk_req}, {31'b0, e});
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_addr[c] = '0; m_mask[c] = '0; m_asid[c] = '0; m_cond[c] = '0;
    end
    m_dat = '0; m_dmask = '0; m_flags = '0;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    mon_valid = 1'b0; mon_addr = '0; mon_data = '0; mon_asid = '0;
    mon_dom = '0; mon_fetch = 1'b0; mon_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(brk_req === 1'b0, "R1 reset request", {31'b0, brk_req}, 32'd0);
    rst_n = 1'b1;
    for (int r = 0; r <= 10; r++) rd(4'(r), "R1 reset register value");

    // channel A: L bus, fetch or data, read only; low nibble don't-care
    wr(4'd0, 32'h1000_0040); wr(4'd1, 32'h0000_000F); wr(4'd2, 32'h12); wr(4'd3, 32'h1D);
    for (int r = 0; r <= 3; r++) rd(4'(r), "R12 readback A");
    bus(32'h1000_004C, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, "R2 masked address hit");
    bus(32'h1000_0050, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, "R2 unmasked bit differs");
    bus(32'h1000_0040, 32'h0, 8'h13, 2'b00, 1'b0, 1'b0, "R3 identifier mismatch");
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b1, "R4 write rejected");
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b01, 1'b0, 1'b0, "R4 I bus rejected");
    bus(32'h1000_0041, 32'h0, 8'h12, 2'b00, 1'b1, 1'b0, "R4 fetch accepted");
    cyc(1'b0, 32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, 1'b0, 4'd0, '0, "R7 invalid cycle");
    rd(4'd10, "R8 A-L flag set");

    wr(4'd10, 32'hF);  rd(4'd10, "R10 write one keeps flag");
    wr(4'd10, 32'h0);  rd(4'd10, "R10 write zero clears");
    cyc(1'b1, 32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, 1'b1, 4'd10, 32'h0, "R10 set with clear");
    rd(4'd10, "R10 set wins over clear");
    wr(4'd10, 32'h0);

    wr(4'd3, 32'h1C);
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, "R5 domain 00");
    wr(4'd3, 32'h11);
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, "R5 kind 00");
    wr(4'd3, 32'h0D);
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b00, 1'b0, 1'b0, "R5 direction 00");
    rd(4'd10, "R5 no flag while disabled");

    // channel B: I bus, data, write, upper data half compared
    wr(4'd4, 32'h2000_0000); wr(4'd5, 32'h0); wr(4'd6, 32'h05); wr(4'd7, 32'h2A);
    wr(4'd8, 32'hAABB_0000); wr(4'd9, 32'h0000_FFFF);
    for (int r = 4; r <= 9; r++) rd(4'(r), "R12 readback B");
    bus(32'h2000_0000, 32'hAABB_1234, 8'h05, 2'b01, 1'b0, 1'b1, "R6 masked data hit");
    rd(4'd10, "R8 B-I flag set");
    bus(32'h2000_0000, 32'hAABC_0000, 8'h05, 2'b01, 1'b0, 1'b1, "R6 data differs");
    bus(32'h2000_0004, 32'hAABB_0000, 8'h05, 2'b01, 1'b0, 1'b1, "R2 zero mask exact");
    wr(4'd3, 32'h1D);
    bus(32'h1000_0040, 32'hDEAD_BEEF, 8'h12, 2'b00, 1'b0, 1'b0, "R6 A ignores data");

    // X/Y domain on channel B
    wr(4'd10, 32'h0);
    wr(4'd7, 32'h7D); wr(4'd3, 32'h1F);
    bus(32'h2000_0000, 32'hAABB_0000, 8'h05, 2'b10, 1'b0, 1'b0, "R9 X/Y hit on B");
    rd(4'd10, "R9 X/Y sets B-L");
    bus(32'h1000_0040, 32'h0, 8'h12, 2'b10, 1'b0, 1'b0, "R9 A ignores X/Y");
    bus(32'h2000_0000, 32'hAABB_0000, 8'h05, 2'b11, 1'b0, 1'b0, "R9 reserved domain");
    wr(4'd7, 32'h3D);
    bus(32'h2000_0000, 32'hAABB_0000, 8'h05, 2'b10, 1'b0, 1'b0, "R9 X/Y off");
    rd(4'd10, "R9 flags unchanged");

    // both channels on one cycle
    wr(4'd10, 32'h0);
    wr(4'd0, 32'h2000_0000); wr(4'd2, 32'h05); wr(4'd3, 32'h3F); wr(4'd7, 32'h3F);
    bus(32'h2000_0000, 32'hAABB_0000, 8'h05, 2'b01, 1'b0, 1'b0, "R11 both hit one request");
    cyc(1'b0, '0, '0, '0, 2'b00, 1'b0, 1'b0, 1'b0, 4'd0, '0, "R11 no second pulse");
    rd(4'd10, "R11 both I flags");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule